// File: doc/BRIEF.md
# Three-Phase Sine Reference Synthesizer

This block produces three sinusoidal reference waveforms for an open-loop modulator by direct digital synthesis. A shared phase accumulator moves forward by a programmable fractional step on every update strobe. Each phase adds its own phase-word offset to the accumulator. The upper bits of that sum address a full-period table of signed sine samples. The three table reads are registered, and a one-cycle valid pulse marks each new set of samples.

The step is expressed as a fraction of one waveform period per update. If the generator is strobed only once every N clocks, the caller scales the per-clock value by N. Phase offsets come in as times in nanoseconds. A caller-supplied factor converts them to phase words, and that factor is the phase step per nanosecond. The step may be changed at any time. The accumulator is never cleared by such a change, so the waveform continues from where it was.

Top module: `tri_phase_dds`

## Requirements
- R1: While `rst` is high, at the next clock edge `wave_vld` goes to 0, all three samples go to 0 and the accumulator goes to 0. The first update after reset therefore uses phase 0 plus each phase's offset.
- R2: `wave_vld` is high in the cycle after each cycle in which `upd_en` is sampled high, and it is low after any cycle in which `upd_en` is low.
- R3: Each sample in the update cycle equals round(32767·sin(2π·k/1024)), where k is bits [31:22] of the 32-bit sum of the accumulator value before the update and that phase's offset word. This gives k=0 → 0, k=256 → 32767, k=512 → 0 and k=768 → -32767.
- R4: Every update adds `freq_inc` to the accumulator modulo 2^32. The accumulator is unchanged when `upd_en` is low.
- R5: Each phase's offset word is the low 32 bits of the unsigned product of its 24-bit nanosecond offset and `ns_scale`. When the product overflows, only its low 32 bits are used.
- R6: A new `freq_inc` applies to the update in which it is presented and leaves the accumulator as it is, so the next table index continues from the accumulated phase.
- R7: Between updates all three samples hold their last values.
- R8: The three phases share the accumulator but use independent offsets. Phase A drives `wave_a`, phase B drives `wave_b` and phase C drives `wave_c`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en | input | 1 | Update strobe; one accumulator step and table read per high cycle |
| freq_inc | input | 32 | Phase step per update, as a fraction of a period times 2^32 |
| ns_scale | input | 32 | Phase-word units per nanosecond of offset |
| off_a_ns | input | 24 | Phase A time offset in ns |
| off_b_ns | input | 24 | Phase B time offset in ns |
| off_c_ns | input | 24 | Phase C time offset in ns |
| wave_a | output | 16 | Phase A signed sample |
| wave_b | output | 16 | Phase B signed sample |
| wave_c | output | 16 | Phase C signed sample |
| wave_vld | output | 1 | One-cycle pulse marking new samples |

## Verification
If the accumulator holds a wrong value, the very next valid pulse shows it on all three samples together, as a shifted table index. A wrong offset conversion shows up on only one output, and it shows up on the first update. A bad step size or a spurious reset of the accumulator on a frequency change does not show in one sample. It shows as the index sequence drifting away from the modelled running sum over the following updates. The bench therefore compares every valid beat against a running-sum model and checks the outputs on every idle cycle for unwanted changes.

// File: rtl/tpdds_pkg.sv
package tpdds_pkg;

    localparam int PHASES   = 3;
    localparam int DEF_ACC  = 32;
    localparam int DEF_ADDR = 10;
    localparam int DEF_SAMP = 16;
    localparam int DEF_NS   = 24;
    localparam real TWO_PI  = 2.0 * 3.141592653589793;

    // Signed table code for entry k of a full-period sine table.
    function automatic int sine_code(input int k, input int addr_w, input int samp_w);
        real amp;
        real ang;
        amp = real'((1 << (samp_w - 1)) - 1);
        ang = TWO_PI * real'(k) / real'(1 << addr_w);
        return $rtoi($floor(amp * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/tpdds_phase_acc.sv
module tpdds_phase_acc #(
    parameter int ACC_W = tpdds_pkg::DEF_ACC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic [ACC_W-1:0] step,
    output logic [ACC_W-1:0] acc_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_o <= '0;
        end else if (step_en) begin
            acc_o <= acc_o + step;
        end
    end
endmodule

// File: rtl/tpdds_ns_to_phase.sv
module tpdds_ns_to_phase #(
    parameter int NS_W  = tpdds_pkg::DEF_NS,
    parameter int ACC_W = tpdds_pkg::DEF_ACC
) (
    input  logic [NS_W-1:0]  ns_off,
    input  logic [ACC_W-1:0] ns_scale,
    output logic [ACC_W-1:0] phase_off
);
    logic [ACC_W-1:0] ns_ext;

    assign ns_ext    = ACC_W'(ns_off);
    assign phase_off = ns_ext * ns_scale;
endmodule

// File: rtl/tpdds_sine_rom.sv
module tpdds_sine_rom #(
    parameter int ADDR_W = tpdds_pkg::DEF_ADDR,
    parameter int SAMP_W = tpdds_pkg::DEF_SAMP
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic signed [SAMP_W-1:0] tbl [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        localparam int CODE = tpdds_pkg::sine_code(k, ADDR_W, SAMP_W);
        assign tbl[k] = CODE[SAMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (rd_en) begin
            data <= tbl[addr];
        end
    end
endmodule

// File: rtl/tri_phase_dds.sv
module tri_phase_dds #(
    parameter int ACC_W  = tpdds_pkg::DEF_ACC,
    parameter int ADDR_W = tpdds_pkg::DEF_ADDR,
    parameter int SAMP_W = tpdds_pkg::DEF_SAMP,
    parameter int NS_W   = tpdds_pkg::DEF_NS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd_en,
    input  logic [ACC_W-1:0]         freq_inc,
    input  logic [ACC_W-1:0]         ns_scale,
    input  logic [NS_W-1:0]          off_a_ns,
    input  logic [NS_W-1:0]          off_b_ns,
    input  logic [NS_W-1:0]          off_c_ns,
    output logic signed [SAMP_W-1:0] wave_a,
    output logic signed [SAMP_W-1:0] wave_b,
    output logic signed [SAMP_W-1:0] wave_c,
    output logic                     wave_vld
);
    import tpdds_pkg::*;

    localparam int SHIFT = ACC_W - ADDR_W;

    logic [ACC_W-1:0]         acc_q;
    logic [NS_W-1:0]          off_ns  [PHASES];
    logic [ACC_W-1:0]         off_wd  [PHASES];
    logic [ACC_W-1:0]         phase_w [PHASES];
    logic [ADDR_W-1:0]        tbl_adr [PHASES];
    logic signed [SAMP_W-1:0] samp    [PHASES];
    logic                     vld_q;

    assign off_ns[0] = off_a_ns;
    assign off_ns[1] = off_b_ns;
    assign off_ns[2] = off_c_ns;

    // Shared accumulator: the table read below sees the pre-update value.
    tpdds_phase_acc #(.ACC_W(ACC_W)) i_acc (
        .clk     (clk),
        .rst     (rst),
        .step_en (upd_en),
        .step    (freq_inc),
        .acc_o   (acc_q)
    );

    for (genvar p = 0; p < PHASES; p++) begin : g_ph
        tpdds_ns_to_phase #(.NS_W(NS_W), .ACC_W(ACC_W)) i_cvt (
            .ns_off    (off_ns[p]),
            .ns_scale  (ns_scale),
            .phase_off (off_wd[p])
        );

        assign phase_w[p] = acc_q + off_wd[p];
        assign tbl_adr[p] = ADDR_W'(phase_w[p] >> SHIFT);

        tpdds_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) i_rom (
            .clk   (clk),
            .rst   (rst),
            .rd_en (upd_en),
            .addr  (tbl_adr[p]),
            .data  (samp[p])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= upd_en;
        end
    end

    assign wave_a   = samp[0];
    assign wave_b   = samp[1];
    assign wave_c   = samp[2];
    assign wave_vld = vld_q;
endmodule

// File: rtl/tri_phase_dds_chk.sv
module tri_phase_dds_chk #(
    parameter int ACC_W  = 32,
    parameter int SAMP_W = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     upd_en,
    input logic [ACC_W-1:0]         freq_inc,
    input logic [ACC_W-1:0]         acc,
    input logic                     wave_vld,
    input logic signed [SAMP_W-1:0] wave_a,
    input logic signed [SAMP_W-1:0] wave_b,
    input logic signed [SAMP_W-1:0] wave_c
);
    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!wave_vld && wave_a == 0 && wave_b == 0 && wave_c == 0 && acc == 0)); // R1

    AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> wave_vld); // R2

    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> !wave_vld); // R2

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> acc == ACC_W'($past(acc) + $past(freq_inc))); // R4

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(acc)); // R4

    AST_HOLD_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        !wave_vld |-> ($stable(wave_a) && $stable(wave_b) && $stable(wave_c))); // R7
endmodule

bind tri_phase_dds tri_phase_dds_chk #(.ACC_W(ACC_W), .SAMP_W(SAMP_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .upd_en   (upd_en),
    .freq_inc (freq_inc),
    .acc      (acc_q),
    .wave_vld (wave_vld),
    .wave_a   (wave_a),
    .wave_b   (wave_b),
    .wave_c   (wave_c)
);

// File: tb/test_tri_phase_dds.sv
module test_tri_phase_dds;

    typedef struct {
        int    cyc;
        int    a;
        int    b;
        int    c;
        string tag;
    } exp_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               upd_en = 1'b0;
    logic [31:0]        freq_inc = '0;
    logic [31:0]        ns_scale = '0;
    logic [23:0]        off_a_ns = '0;
    logic [23:0]        off_b_ns = '0;
    logic [23:0]        off_c_ns = '0;
    logic signed [15:0] wave_a;
    logic signed [15:0] wave_b;
    logic signed [15:0] wave_c;
    logic               wave_vld;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    longint unsigned acc_m = 0;
    exp_t sbq[$];
    logic signed [15:0] last_a = '0;
    logic signed [15:0] last_b = '0;
    logic signed [15:0] last_c = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tri_phase_dds i_tri_phase_dds (
        .clk      (clk),
        .rst      (rst),
        .upd_en   (upd_en),
        .freq_inc (freq_inc),
        .ns_scale (ns_scale),
        .off_a_ns (off_a_ns),
        .off_b_ns (off_b_ns),
        .off_c_ns (off_c_ns),
        .wave_a   (wave_a),
        .wave_b   (wave_b),
        .wave_c   (wave_c),
        .wave_vld (wave_vld)
    );

    function automatic int rom_model(input longint unsigned k);
        real r;
        r = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k) / 1024.0);
        return $rtoi($floor(r + 0.5));
    endfunction

    function automatic longint unsigned offw(input logic [23:0] ns);
        return (longint'(ns) * longint'(ns_scale)) & 64'hFFFF_FFFF;
    endfunction

    function automatic int lookup(input logic [23:0] ns);
        longint unsigned ph;
        ph = (acc_m + offw(ns)) & 64'hFFFF_FFFF;
        return rom_model(ph >> 22);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Driver: one cycle per call; pushes the expected beat when strobing.
    task automatic step(input bit en, input logic [31:0] inc, input string tag);
        exp_t e;
        @(negedge clk);
        upd_en   = en;
        freq_inc = inc;
        if (en) begin
            e.cyc = cyc + 1;
            e.a   = lookup(off_a_ns);
            e.b   = lookup(off_b_ns);
            e.c   = lookup(off_c_ns);
            e.tag = tag;
            sbq.push_back(e);
            acc_m = (acc_m + inc) & 64'hFFFF_FFFF;
        end
    endtask

    task automatic cfg(input logic [31:0] sc, input logic [23:0] a,
                       input logic [23:0] b, input logic [23:0] c);
        @(negedge clk);
        upd_en   = 1'b0;
        ns_scale = sc;
        off_a_ns = a;
        off_b_ns = b;
        off_c_ns = c;
    endtask

    task automatic do_reset();
        @(negedge clk);
        upd_en = 1'b0;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        rst   = 1'b0;
        acc_m = 0;
    endtask

    // Monitor: compares each valid beat, checks hold on idle cycles.
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (wave_vld) begin
                if (sbq.size() == 0) begin
                    chk(1'b0, "R2 unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = sbq.pop_front();
                    chk(e.cyc == cyc, {"R2 valid cycle ", e.tag}, cyc, e.cyc);
                    chk(wave_a == e.a, {"R3/R8 wave_a ", e.tag}, wave_a, e.a);
                    chk(wave_b == e.b, {"R3/R5/R8 wave_b ", e.tag}, wave_b, e.b);
                    chk(wave_c == e.c, {"R3/R5/R8 wave_c ", e.tag}, wave_c, e.c);
                end
            end else begin
                chk(wave_a == last_a && wave_b == last_b && wave_c == last_c,
                    "R7 hold between updates", wave_a, last_a);
            end
        end
        last_a = wave_a;
        last_b = wave_b;
        last_c = wave_c;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        chk(wave_vld == 1'b0, "R1 valid in reset", wave_vld, 0);
        chk(wave_a == 0 && wave_b == 0 && wave_c == 0, "R1 samples in reset", wave_a, 0);
        rst = 1'b0;

        // R3/R4: quarter steps give the four cardinal samples, then wrap
        cfg(32'd0, 24'd0, 24'd0, 24'd0);
        step(1'b1, 32'h4000_0000, "quarter0"); step(1'b0, 32'h4000_0000, "idle");
        chk(wave_a == 0, "R1 first update from zero phase", wave_a, 0);
        step(1'b1, 32'h4000_0000, "quarter1"); step(1'b0, 32'h4000_0000, "idle");
        chk(wave_a == 32767, "R3 index 256", wave_a, 32767);
        step(1'b1, 32'h4000_0000, "quarter2"); step(1'b0, 32'h4000_0000, "idle");
        chk(wave_a == 0, "R3 index 512", wave_a, 0);
        step(1'b1, 32'h4000_0000, "quarter3"); step(1'b0, 32'h4000_0000, "idle");
        chk(wave_a == -32767, "R3 index 768", wave_a, -32767);
        step(1'b1, 32'h4000_0000, "wrap"); step(1'b0, 32'h4000_0000, "idle");
        chk(wave_a == 0, "R4 accumulator wraps", wave_a, 0);

        // R5/R8: offsets expressed in ns map to independent table shifts
        do_reset();
        cfg(32'h0040_0000, 24'd0, 24'd256, 24'd768);
        step(1'b1, 32'h0, "offset"); step(1'b0, 32'h0, "idle");
        chk(wave_a == 0,      "R8 phase A no offset", wave_a, 0);
        chk(wave_b == 32767,  "R5 phase B offset 256", wave_b, 32767);
        chk(wave_c == -32767, "R5 phase C offset 768", wave_c, -32767);
        cfg(32'hFFFF_FFFF, 24'h00_0001, 24'hFF_FFFF, 24'h80_0000);
        step(1'b1, 32'h0, "product wrap"); step(1'b0, 32'h0, "idle");
        chk(wave_b == rom_model(1020), "R5 product overflow", wave_b, rom_model(1020));

        // R6: on-the-fly step change keeps the running phase
        do_reset();
        cfg(32'd0, 24'd0, 24'd0, 24'd0);
        repeat (3) step(1'b1, 32'h0040_0000, "slow");
        step(1'b1, 32'h0140_0000, "retune"); step(1'b0, 32'h0, "idle");
        chk(wave_a == rom_model(3), "R6 no phase reset", wave_a, rom_model(3));
        step(1'b1, 32'h0140_0000, "fast"); step(1'b0, 32'h0, "idle");
        chk(wave_a == rom_model(8), "R6 new step applied", wave_a, rom_model(8));

        // Three-phase run at 120 degree spacing, continuous strobe
        cfg(32'd3072, 24'd0, 24'd466034, 24'd932068);
        for (int i = 0; i < 40; i++) step(1'b1, 32'h0123_4567 + 32'(i * 977), "3ph run");

        // Strobe every 5 cycles with a 5x step, idle gaps checked for hold (R7)
        for (int i = 0; i < 30; i++) begin
            step(1'b1, 32'h0A3D_70A5, "decimated");
            repeat (4) step(1'b0, 32'h0, "gap");
        end

        // Large step near full period (R4 wrap under continuous strobe)
        for (int i = 0; i < 20; i++) step(1'b1, 32'hFFC0_0000, "backward");
        step(1'b0, 32'h0, "drain");
        repeat (3) @(negedge clk);
        chk(sbq.size() == 0, "R2 every strobe produced a beat", sbq.size(), 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule